// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block is the debug-trap logic of a small processor core. It keeps four breakpoint address registers, a breakpoint control register and a debug status register. Privileged code reaches all six through a simple select/write/read register port. Every cycle the pipeline may present one memory access event: a linear address, an access size and an access kind (instruction fetch, data read or data write). The unit compares that event against every enabled breakpoint. It records which breakpoints fired in the sticky status register and raises a one-cycle debug-exception request.

The control register carries, for each breakpoint, a local and a global enable bit and a 4-bit group that holds a length code and a type code. Breakpoint ranges are aligned down to their length, so a four-byte breakpoint covers the whole aligned word. An access hits when its own byte range overlaps that word. Besides address matching, the unit implements single-step trapping. It watches the trap flag at each instruction completion and traps one instruction after the flag turns on. A resume flag masks fetch breakpoints for the instruction being restarted, and the unit asks for that flag to be cleared once the instruction completes.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, dbg_req and resume_clr are 0, the status register reads 0xFFFF0FF0 and the control register reads 0x00000400.
- R2: Breakpoint i is armed when control bit 2i (local) or bit 2i+1 (global) is 1. With both bits 0 it never matches.
- R3: The length code of breakpoint i sits at control bits 19+4i:18+4i. Code 00 means 1 byte, 01 means 2 bytes and 11 means 4 bytes. The range is the stored address aligned down to that size and extended by it, and an access of acc_size (00 = 1, 01 = 2, 1x = 4 bytes) matches when its byte range overlaps that range. Code 10 never matches.
- R4: The type code of breakpoint i sits at control bits 17+4i:16+4i. Code 00 matches fetches only, 01 matches data writes only, and 11 matches data reads and writes but not fetches. Code 10 never matches. acc_kind is encoded 00 fetch, 01 write, 10 read, 11 no access.
- R5: Status bits 3:0 are set for each breakpoint that matched. They and the single-step bit stay set until a register write to the status register, and bits of breakpoints that did not match keep their value.
- R6: dbg_req is 1 in the cycle after a cycle holding a match or a single-step trap, and is 0 otherwise.
- R7: While rf is 1, fetch-type breakpoints do not match. Data breakpoints are unaffected.
- R8: resume_clr is 1 in the cycle after a cycle where insn_end and rf are both 1, and 0 otherwise.
- R9: A single-step trap is taken at an insn_end where tf is 1 and tf was also 1 at the previous insn_end. The instruction that turns tf on does not trap. The trap sets status bit 14.
- R10: Status bits 31:16 and 11:4 read as 1 and bit 12 reads as 0. Control bit 10 reads as 1, and control bits 15:14 and 12:11 read as 0.
- R11: reg_rdata presents, one cycle after reg_sel is applied, the register it selects: 0 to 3 the breakpoint addresses, 4 control, 5 status, 6 and 7 zero. A write with reg_wr takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0-3 address, 4 control, 5 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| acc_valid | input | 1 | An access event is present this cycle |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size: 00 1 byte, 01 2 bytes, 1x 4 bytes |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 none |
| tf | input | 1 | Trap flag from the flags register |
| rf | input | 1 | Resume flag from the flags register |
| insn_end | input | 1 | An instruction completes this cycle |
| dbg_req | output | 1 | Debug-exception request pulse |
| resume_clr | output | 1 | Request to clear the resume flag |

## Verification
The assertions assume that accesses and instruction completions arrive only through acc_valid and insn_end. They also assume that the status register is changed by software only through a status-select write. The sticky and cause checks rely on both. They further assume that access ranges do not wrap past the top of the address space. The stimulus keeps every address far from that boundary and never writes the status register in a cycle that also carries an access or an instruction completion, so hardware and software updates never collide.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int REG_W = 32;
  localparam int NBP   = 4;
  localparam int SEL_W = 3;
  localparam int GRP_W = 4;
  localparam int GRP_BASE = 16;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFFF_23FF;
  localparam logic [REG_W-1:0] CTRL_ONES = 32'h0000_0400;
  localparam logic [REG_W-1:0] STAT_KEEP = 32'h0000_E00F;
  localparam logic [REG_W-1:0] STAT_ONES = 32'hFFFF_0FF0;
  localparam int STAT_STEP_BIT = 14;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/bkpt_comparator.sv
module bkpt_comparator #(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic          armed,
  input  logic [1:0]    len_code,
  input  logic [1:0]    type_code,
  input  logic [AW-1:0] bp_addr,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  input  logic          rf,
  output logic          hit
);
  import bkpt_pkg::*;
  localparam int XW = AW + 1;

  logic [XW-1:0] bp_bytes, acc_bytes, bp_lo, bp_hi, acc_lo, acc_hi;
  logic          len_ok, type_ok, overlap;

  always_comb begin
    len_ok = 1'b1;
    case (len_code)
      2'b00:   bp_bytes = XW'(1);
      2'b01:   bp_bytes = XW'(2);
      2'b11:   bp_bytes = XW'(4);
      default: begin bp_bytes = XW'(1); len_ok = 1'b0; end
    endcase
    case (acc_size)
      2'b00:   acc_bytes = XW'(1);
      2'b01:   acc_bytes = XW'(2);
      default: acc_bytes = XW'(4);
    endcase
    bp_lo  = {1'b0, bp_addr} & ~(bp_bytes - XW'(1));
    bp_hi  = bp_lo + bp_bytes - XW'(1);
    acc_lo = {1'b0, acc_addr};
    acc_hi = acc_lo + acc_bytes - XW'(1);
    overlap = (acc_lo <= bp_hi) && (bp_lo <= acc_hi);
    case (type_code)
      2'b00:   type_ok = (acc_kind == ACC_FETCH) && !rf;
      2'b01:   type_ok = (acc_kind == ACC_WRITE);
      2'b11:   type_ok = (acc_kind == ACC_WRITE) || (acc_kind == ACC_READ);
      default: type_ok = 1'b0;
    endcase
    hit = valid && armed && len_ok && type_ok && overlap;
  end
endmodule

// File: rtl/bkpt_step_ctl.sv
module bkpt_step_ctl (
  input  logic clk,
  input  logic rst,
  input  logic insn_end,
  input  logic tf,
  input  logic rf,
  output logic step_fire,
  output logic resume_clr
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      resume_clr <= 1'b0;
    end else begin
      resume_clr <= insn_end && rf;
      if (insn_end) armed_q <= tf;
    end
  end

  assign step_fire = insn_end && tf && armed_q;
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [1:0]  acc_kind,
  input  logic        tf,
  input  logic        rf,
  input  logic        insn_end,
  output logic        dbg_req,
  output logic        resume_clr
);
  import bkpt_pkg::*;

  logic [REG_W-1:0] bp_addr [NBP];
  logic [REG_W-1:0] ctrl_q, stat_q, stat_nx;
  logic [NBP-1:0]   hits;
  logic             step_fire;

  // breakpoint comparators, one per address register
  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    bkpt_comparator #(.AW(REG_W)) u_cmp (
      .valid    (acc_valid),
      .armed    (ctrl_q[2*i] | ctrl_q[2*i+1]),
      .len_code (ctrl_q[GRP_BASE + GRP_W*i + 2 +: 2]),
      .type_code(ctrl_q[GRP_BASE + GRP_W*i +: 2]),
      .bp_addr  (bp_addr[i]),
      .acc_addr (acc_addr),
      .acc_size (acc_size),
      .acc_kind (acc_kind),
      .rf       (rf),
      .hit      (hits[i])
    );
  end

  bkpt_step_ctl u_step (
    .clk       (clk),
    .rst       (rst),
    .insn_end  (insn_end),
    .tf        (tf),
    .rf        (rf),
    .step_fire (step_fire),
    .resume_clr(resume_clr)
  );

  // software write first, hardware causes OR in on top
  always_comb begin
    stat_nx = (reg_wr && reg_sel == SEL_STAT) ? reg_wdata : stat_q;
    stat_nx[NBP-1:0] = stat_nx[NBP-1:0] | hits;
    stat_nx[STAT_STEP_BIT] = stat_nx[STAT_STEP_BIT] | step_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBP; i++) bp_addr[i] <= '0;
    end else if (reg_wr && !reg_sel[2]) begin
      bp_addr[reg_sel[1:0]] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      stat_q    <= '0;
      dbg_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
      stat_q  <= stat_nx;
      dbg_req <= (|hits) || step_fire;
      case (reg_sel)
        3'd0, 3'd1, 3'd2, 3'd3: reg_rdata <= bp_addr[reg_sel[1:0]];
        SEL_CTRL: reg_rdata <= (ctrl_q & CTRL_KEEP) | CTRL_ONES;
        SEL_STAT: reg_rdata <= (stat_q & STAT_KEEP) | STAT_ONES;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [2:0] reg_sel,
  input logic       acc_valid,
  input logic [1:0] acc_kind,
  input logic       rf,
  input logic       tf,
  input logic       insn_end,
  input logic       dbg_req,
  input logic       resume_clr,
  input logic [3:0] stat_b,
  input logic       stat_bs
);
  logic sw_stat;
  assign sw_stat = reg_wr && (reg_sel == 3'd5);

  // R6: a request always follows an access or an instruction completion
  p_req_cause_r6: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> $past(acc_valid || insn_end));

  // R8: resume clear only after a completing instruction under rf
  p_resume_clr_r8: assert property (@(posedge clk) disable iff (rst)
    resume_clr |-> $past(insn_end && rf));

  // R7: fetch under rf with no completion gives no request
  p_rf_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b00 && rf && !insn_end) |=> !dbg_req);

  // R5: breakpoint status bits never drop without a status write
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_stat) |-> ((stat_b & $past(stat_b)) == $past(stat_b)));

  // R9: the step status bit rises only from a trap under tf
  p_step_src_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(sw_stat) && stat_bs && !$past(stat_bs)) |-> $past(insn_end && tf));
endmodule

bind bkpt_match_unit bkpt_match_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .acc_valid (acc_valid),
  .acc_kind  (acc_kind),
  .rf        (rf),
  .tf        (tf),
  .insn_end  (insn_end),
  .dbg_req   (dbg_req),
  .resume_clr(resume_clr),
  .stat_b    (stat_q[3:0]),
  .stat_bs   (stat_q[14])
);

// File: tb/bkpt_match_unit_bench.sv
`timescale 1ns/1ps
module bkpt_match_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = 2'b00;
  logic [1:0]  acc_kind = 2'b11;
  logic        tf = 1'b0, rf = 1'b0, insn_end = 1'b0;
  logic        dbg_req, resume_clr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bkpt_match_unit u_bkpt_match_unit (.*);

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [1:0]  kind;
    logic        rfv;
    logic        req;
    logic [3:0]  b;
  } vec_t;

  // breakpoint addresses: bp0 0x1000, bp1 0x1006, bp2 0x3005, bp3 0x4000
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 32'h1000, 2'd0, 2'b00, 1'b0, 1'b1, 4'b0001}, // R2 local, R4 fetch
    '{32'h0000_0001, 32'h1001, 2'd0, 2'b00, 1'b0, 1'b0, 4'b0000}, // R3 outside 1 byte
    '{32'h0000_0002, 32'h1000, 2'd0, 2'b00, 1'b0, 1'b1, 4'b0001}, // R2 global
    '{32'h0000_0000, 32'h1000, 2'd0, 2'b00, 1'b0, 1'b0, 4'b0000}, // R2 disabled
    '{32'h000D_0001, 32'h1003, 2'd0, 2'b01, 1'b0, 1'b1, 4'b0001}, // R3 4-byte write
    '{32'h000D_0001, 32'h1003, 2'd0, 2'b10, 1'b0, 1'b0, 4'b0000}, // R4 read on write-only
    '{32'h000D_0001, 32'h0FFF, 2'd1, 2'b01, 1'b0, 1'b1, 4'b0001}, // R3 overlap from below
    '{32'h000D_0001, 32'h0FFE, 2'd1, 2'b01, 1'b0, 1'b0, 4'b0000}, // R3 just below
    '{32'h000D_0001, 32'h1000, 2'd0, 2'b00, 1'b0, 1'b0, 4'b0000}, // R4 fetch on write-only
    '{32'h0070_0004, 32'h1007, 2'd0, 2'b10, 1'b0, 1'b1, 4'b0010}, // R4 read on rw
    '{32'h0070_0004, 32'h1005, 2'd0, 2'b01, 1'b0, 1'b0, 4'b0000}, // R3 below 2-byte
    '{32'h0B00_0010, 32'h3005, 2'd0, 2'b10, 1'b0, 1'b0, 4'b0000}, // R3 length 10
    '{32'h0200_0010, 32'h3005, 2'd0, 2'b10, 1'b0, 1'b0, 4'b0000}, // R4 type 10
    '{32'hC000_0080, 32'h4002, 2'd0, 2'b00, 1'b1, 1'b0, 4'b0000}, // R7 fetch masked
    '{32'hC000_0080, 32'h4002, 2'd0, 2'b00, 1'b0, 1'b1, 4'b1000}, // R7 fetch unmasked
    '{32'hF000_0040, 32'h4001, 2'd2, 2'b01, 1'b1, 1'b1, 4'b1000}, // R7 data not masked
    '{32'h007F_0005, 32'h1003, 2'd2, 2'b10, 1'b0, 1'b1, 4'b0011}, // R5 two hits
    '{32'h0F00_0010, 32'h3007, 2'd0, 2'b10, 1'b0, 1'b1, 4'b0100}, // R3 aligned down
    '{32'h0F00_0010, 32'h3008, 2'd0, 2'b10, 1'b0, 1'b0, 4'b0000}  // R3 past aligned word
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    step();
    d = reg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] s, input logic [1:0] k,
                        output logic req);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_kind = k;
    step();
    acc_valid = 1'b0; acc_kind = 2'b11;
    req = dbg_req;
  endtask

  task automatic iend(input logic t, output logic req);
    tf = t; insn_end = 1'b1;
    step();
    insn_end = 1'b0;
    req = dbg_req;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        q;
    repeat (3) step();
    rst = 1'b0;
    chk("R1 dbg_req after reset", {31'b0, dbg_req}, 32'd0);
    chk("R1 resume_clr after reset", {31'b0, resume_clr}, 32'd0);
    rd(3'd5, d); chk("R1 status reset", d, 32'hFFFF_0FF0);
    rd(3'd4, d); chk("R1 control reset", d, 32'h0000_0400);

    // R11 readback and R10 fixed bits
    wr(3'd2, 32'hDEAD_BEEF);
    rd(3'd2, d); chk("R11 address readback", d, 32'hDEAD_BEEF);
    rd(3'd6, d); chk("R11 unused select", d, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R10 control fixed bits", d, 32'hFFFF_27FF);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R10 status fixed bits", d, 32'hFFFF_EFFF);
    wr(3'd5, 32'h0);

    wr(3'd0, 32'h1000); wr(3'd1, 32'h1006);
    wr(3'd2, 32'h3005); wr(3'd3, 32'h4000);

    for (int i = 0; i < NV; i++) begin
      wr(3'd5, 32'h0);
      wr(3'd4, VECS[i].ctrl);
      rf = VECS[i].rfv;
      access(VECS[i].addr, VECS[i].size, VECS[i].kind, q);
      chk($sformatf("R6 vec%0d dbg_req", i), {31'b0, q}, {31'b0, VECS[i].req});
      rf = 1'b0;
      step();
      chk($sformatf("R6 vec%0d pulse end", i), {31'b0, dbg_req}, 32'd0);
      rd(3'd5, d);
      chk($sformatf("R5 vec%0d status", i), d, 32'hFFFF_0FF0 | {28'b0, VECS[i].b});
    end

    // R5 sticky across two separate hits
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0070_0005);
    access(32'h1000, 2'd0, 2'b00, q);
    access(32'h1006, 2'd0, 2'b10, q);
    access(32'h2000, 2'd0, 2'b10, q);
    rd(3'd5, d); chk("R5 sticky status", d, 32'hFFFF_0FF3);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R5 status cleared by write", d, 32'hFFFF_0FF0);
    wr(3'd4, 32'h0);

    // R8 resume clear
    rf = 1'b1;
    step();
    chk("R8 no clear without insn_end", {31'b0, resume_clr}, 32'd0);
    iend(1'b0, q);
    chk("R8 clear after insn_end", {31'b0, resume_clr}, 32'd1);
    rf = 1'b0;
    step();
    chk("R8 clear is one cycle", {31'b0, resume_clr}, 32'd0);
    iend(1'b0, q);
    chk("R8 no clear with rf low", {31'b0, resume_clr}, 32'd0);

    // R9 single step
    iend(1'b0, q); chk("R9 no trap tf low", {31'b0, q}, 32'd0);
    iend(1'b1, q); chk("R9 setting instruction no trap", {31'b0, q}, 32'd0);
    step();
    iend(1'b1, q); chk("R9 trap next instruction", {31'b0, q}, 32'd1);
    rd(3'd5, d); chk("R9 step status bit", d, 32'hFFFF_4FF0);
    iend(1'b0, q); chk("R9 no trap after tf clear", {31'b0, q}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule